// File: doc/BRIEF.md
# Three-Wire Serial Memory Burst Reader

This block is the host side of a read from a three-wire serial memory with 16-bit words and a 9-bit word address. A single command carries the start address, the number of words less one, and a count of leading padding clocks. The block raises chip select and builds the serial clock by dividing the system clock. It shifts out the padding clocks, then the read header and the address. It checks the zero bit the memory returns after the last address bit, and then keeps clocking to collect as many consecutive words as the command asked for.

Each collected word is presented for one system clock together with the memory address it came from. When the last word has been collected, chip select drops and is held low for a programmable minimum time. Only then does the block pulse done and accept the next command. The block does not write, erase or poll status.

Top module: `serial_rd_master`

## Requirements
- R1: After reset, chip select, serial clock, serial data-out to the memory, busy, done, error and word valid are all low.
- R2: A command is taken on a clock edge where cmd_valid is high and busy is low, and busy is high from the next cycle. While busy is high, cmd_valid has no effect on the transfer in progress and starts no new frame. Busy falls only in the cycle done is high.
- R3: Chip select rises while the serial clock is low, and the serial clock stays low whenever chip select is low. Every low half and every high half of the serial clock lasts HALF_DIV system clocks, and the first low half starts when chip select rises.
- R4: Before the start bit, exactly cmd_dummy rising serial clock edges occur with the memory data input low.
- R5: After the padding, the memory sees on successive rising edges: 1 (start), 1, 0, a 0 in place of the don't-care bit, and then the address from bit 8 down to bit 0.
- R6: The data line to the memory changes only while the serial clock is low.
- R7: The memory output is sampled at the end of the high half that follows the rising edge carrying address bit 0. If that sample is 1, err is set. err stays set until the next command is taken, and the transfer still completes.
- R8: Data bits are sampled at the end of each high half, most significant bit first. Each 16-bit word appears on rd_data with rd_addr for a single-cycle rd_valid pulse.
- R9: A command returns cmd_len+1 words from consecutive addresses without resending the address, and address 511 is followed by address 0.
- R10: After the last word, chip select drops. done pulses for one cycle, with busy low and chip select low. Chip select stays low for at least CS_GAP system clocks before it rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_addr | input | 9 | First word address |
| cmd_len | input | 10 | Number of words minus one |
| cmd_dummy | input | 4 | Padding clocks before the start bit |
| busy | output | 1 | Transfer in progress; commands ignored |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Zero bit after the address was read as 1 |
| mem_cs | output | 1 | Chip select to the memory |
| mem_sk | output | 1 | Serial clock to the memory |
| mem_di | output | 1 | Serial data to the memory |
| mem_do | input | 1 | Serial data from the memory |
| rd_valid | output | 1 | Word strobe |
| rd_data | output | 16 | Received word |
| rd_addr | output | 9 | Address of the received word |

## Verification
The bench builds the block with HALF_DIV=2, CS_GAP=3 and a 10-bit length field. These settings keep one serial bit to four system clocks, so a single burst of 513 words starting at address 7 visits every address, wraps past 511 and stays well within the cycle budget. A sweep of all sixteen padding counts, a short burst across the wrap point, a one-word read at address 511 and a forced bad zero bit complete the coverage. The behavioural memory model recomputes every word arithmetically from its address, and it records the padding count, header bits and address it received.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAD,
    ST_HDR,
    ST_DATA,
    ST_GAP
  } srm_state_t;
endpackage

// File: rtl/srm_sclk_gen.sv
module srm_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sk,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sk      = sk_q;
  assign fall_ev = run && sk_q && (cnt_q == LAST);

  assert_half_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/srm_rx_shift.sv
module srm_rx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              word_done
);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-2:0] sh_q;
  logic [BW-1:0]     bcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (shift_en) begin
      sh_q   <= {sh_q[WORD_W-3:0], din};
      bcnt_q <= (bcnt_q == BW'(WORD_W - 1)) ? '0 : bcnt_q + BW'(1);
    end
  end

  assign word      = {sh_q, din};
  assign word_done = shift_en && (bcnt_q == BW'(WORD_W - 1));
endmodule

// File: rtl/serial_rd_master.sv
module serial_rd_master
  import srm_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int WORD_W   = 16,
  parameter int LEN_W    = 10,
  parameter int DUM_W    = 4,
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DUM_W-1:0]  cmd_dummy,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_cs,
  output logic              mem_sk,
  output logic              mem_di,
  input  logic              mem_do,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int FRAME_W = ADDR_W + 4;
  localparam int BW      = $clog2(FRAME_W);
  localparam int GAP_W   = $clog2(CS_GAP + 1);
  localparam logic [3:0] HDR = 4'b1100;

  srm_state_t        state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DUM_W-1:0]  pad_q;
  logic [BW-1:0]     bidx_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [GAP_W-1:0]  gcnt_q;
  logic              cs_q, di_q, busy_q, done_q, err_q, rv_q;
  logic [WORD_W-1:0] rdata_q;
  logic [ADDR_W-1:0] raddr_q;

  logic              fall_ev, sk_w, word_done;
  logic [WORD_W-1:0] word_w;

  srm_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst(rst), .run(cs_q), .sk(sk_w), .fall_ev(fall_ev)
  );

  srm_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst),
    .shift_en(state_q == ST_DATA && fall_ev),
    .din(mem_do), .word(word_w), .word_done(word_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      pad_q   <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      gcnt_q  <= '0;
      cs_q    <= 1'b0;
      di_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rv_q    <= 1'b0;
      rdata_q <= '0;
      raddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          frame_q <= {HDR, cmd_addr};
          pad_q   <= cmd_dummy;
          left_q  <= cmd_len;
          addr_q  <= cmd_addr;
          bidx_q  <= '0;
          cs_q    <= 1'b1;
          busy_q  <= 1'b1;
          err_q   <= 1'b0;
          di_q    <= (cmd_dummy == '0);
          state_q <= (cmd_dummy == '0) ? ST_HDR : ST_PAD;
        end
        ST_PAD: if (fall_ev) begin
          pad_q <= pad_q - DUM_W'(1);
          if (pad_q == DUM_W'(1)) begin
            di_q    <= frame_q[FRAME_W-1];
            state_q <= ST_HDR;
          end
        end
        ST_HDR: if (fall_ev) begin
          frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
          di_q    <= frame_q[FRAME_W-2];
          bidx_q  <= bidx_q + BW'(1);
          if (bidx_q == BW'(FRAME_W - 1)) begin
            state_q <= ST_DATA;
            if (mem_do) err_q <= 1'b1;
          end
        end
        ST_DATA: if (word_done) begin
          rv_q    <= 1'b1;
          rdata_q <= word_w;
          raddr_q <= addr_q;
          addr_q  <= addr_q + ADDR_W'(1);
          if (left_q == '0) begin
            cs_q    <= 1'b0;
            gcnt_q  <= '0;
            state_q <= ST_GAP;
          end else begin
            left_q <= left_q - LEN_W'(1);
          end
        end
        ST_GAP: begin
          gcnt_q <= gcnt_q + GAP_W'(1);
          if (gcnt_q >= GAP_W'(CS_GAP - 1)) begin
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign mem_cs   = cs_q;
  assign mem_sk   = sk_w;
  assign mem_di   = di_q;
  assign rd_valid = rv_q;
  assign rd_data  = rdata_q;
  assign rd_addr  = raddr_q;

  assert_sk_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_cs |-> !mem_sk);
  assert_di_sk_low_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_di != $past(mem_di)) |-> !mem_sk);
  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_done_released_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_cs));
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/serial_rd_master_test.sv
module serial_rd_master_test;
  localparam int HALF = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [8:0] cmd_addr = '0;
  logic [9:0] cmd_len = '0;
  logic [3:0] cmd_dummy = '0;
  logic busy, done, err, mem_cs, mem_sk, mem_di, rd_valid;
  logic mem_do;
  logic [15:0] rd_data;
  logic [8:0] rd_addr;

  always #5 clk = ~clk;

  serial_rd_master #(.HALF_DIV(HALF), .CS_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_dummy(cmd_dummy), .busy(busy), .done(done),
    .err(err), .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di),
    .mem_do(mem_do), .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] memval(input logic [8:0] a);
    logic [15:0] w;
    w = 16'(a) * 16'h3B1D + 16'h07E5;
    return w ^ {a[3:0], 12'h0};
  endfunction

  // behavioural memory
  logic sk_d = 1'b0, cs_d = 1'b0, bad_zero = 1'b0;
  logic do_q = 1'b0;
  int k = 0, npad = 0, nframes = 0;
  logic [2:0] hdr = '0;
  logic [8:0] cap = '0;
  assign mem_do = do_q;

  always @(posedge clk) begin
    sk_d <= mem_sk;
    cs_d <= mem_cs;
    if (mem_cs && !cs_d) begin
      k <= 0; npad <= 0; hdr <= '0; nframes <= nframes + 1;
    end else if (mem_cs && mem_sk && !sk_d) begin
      if (k == 0) begin
        if (mem_di) k <= 1; else npad <= npad + 1;
      end else begin
        k <= k + 1;
        if (k <= 3) hdr <= {hdr[1:0], mem_di};
        else if (k <= 12) cap <= {cap[7:0], mem_di};
        if (k == 12) do_q <= bad_zero;
        else if (k >= 13) begin
          logic [15:0] w;
          w = memval(9'(int'(cap) + (k - 13) / 16));
          do_q <= w[15 - ((k - 13) % 16)];
        end
      end
    end
  end

  // monitors
  logic [8:0] exp_addr = '0;
  int got = 0, half_bad = 0, gap_bad = 0, di_bad = 0, run_len = 0, low_len = 0;
  logic lvl = 1'b0, di_p = 1'b0, cs_p = 1'b0, seen = 1'b0;

  always @(negedge clk) if (!rst) begin
    if (rd_valid) begin
      check(rd_data == memval(exp_addr), "R8 data", rd_data, memval(exp_addr));
      check(rd_addr == exp_addr, "R9 addr", rd_addr, exp_addr);
      exp_addr <= exp_addr + 9'd1;
      got <= got + 1;
    end
    if (mem_cs) begin
      if (mem_sk == lvl) run_len <= run_len + 1;
      else begin
        if (run_len != HALF) half_bad <= half_bad + 1;
        lvl <= mem_sk; run_len <= 1;
      end
    end else begin
      if (mem_sk) half_bad <= half_bad + 1;
      lvl <= 1'b0; run_len <= 0;
    end
    if (mem_cs && !cs_p && seen && low_len < GAP) gap_bad <= gap_bad + 1;
    if (!mem_cs) low_len <= low_len + 1; else low_len <= 0;
    if (cs_p && !mem_cs) seen <= 1'b1;
    if (mem_di != di_p && mem_sk) di_bad <= di_bad + 1;
    di_p <= mem_di;
    cs_p <= mem_cs;
  end

  task automatic run_read(input logic [8:0] a, input int len, input int pad, input bit bad);
    int f0;
    @(negedge clk);
    while (busy) @(negedge clk);
    bad_zero = bad;
    exp_addr = a;
    got = 0;
    f0 = nframes;
    cmd_addr = a; cmd_len = 10'(len); cmd_dummy = 4'(pad); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    check(got == len + 1, "R9 word count", got, len + 1);
    check(err == bad, "R7 zero-bit flag", err, bad);
    check(npad == pad, "R4 padding clocks", npad, pad);
    check(hdr == 3'b100, "R5 header bits", hdr, 3'b100);
    check(cap == a, "R5 address bits", cap, a);
    check(!mem_cs && !busy, "R10 released at done", {mem_cs, busy}, 0);
    check(nframes == f0 + 1, "R2 one frame", nframes - f0, 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_cs && !mem_sk && !mem_di && !busy && !done && !err && !rd_valid,
          "R1 reset state", {mem_cs, mem_sk, mem_di, busy, done, err, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_cs && !busy, "R1 idle after reset", {mem_cs, busy}, 0);

    for (int d = 0; d < 16; d++) run_read(9'(37 * d + 3), 2, d, 1'b0);
    run_read(9'd505, 11, 1, 1'b0);
    run_read(9'd511, 0, 0, 1'b0);
    run_read(9'd100, 1, 2, 1'b1);
    run_read(9'd101, 1, 0, 1'b0);
    run_read(9'd7, 512, 3, 1'b0);

    // R2: commands during busy are ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_addr = 9'd200; got = 0; bad_zero = 1'b0;
    begin
      int f0;
      f0 = nframes;
      cmd_addr = 9'd200; cmd_len = 10'd3; cmd_dummy = 4'd1; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_addr = 9'd33; cmd_len = 10'd0; cmd_dummy = 4'd5;
      repeat (40) @(negedge clk);
      cmd_valid = 1'b0;
      repeat (30) @(negedge clk);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      check(got == 4, "R2 busy ignores cmd count", got, 4);
      check(npad == 1 && cap == 9'd200, "R2 busy ignores cmd frame", cap, 200);
      check(nframes == f0 + 1, "R2 no extra frame", nframes - f0, 1);
      repeat (10) @(negedge clk);
      check(!mem_cs, "R2 no restart after busy", mem_cs, 0);
    end

    check(half_bad == 0, "R3 clock halves and gating", half_bad, 0);
    check(di_bad == 0, "R6 data changes with clock low", di_bad, 0);
    check(gap_bad == 0, "R10 deselect gap", gap_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule